// File: doc/BRIEF.md
# Two-Bit Mealy Sequence Machine

This block is a small clocked state machine. Two state bits, called A and B, are held in flip-flops. The block has one serial data input and one output. On every rising clock edge the two bits load new values. These values come from fixed next-state equations of the present state and the input. The output is a Mealy output: it is decoded combinationally from the registered state and the live input. It therefore follows the input within a cycle, even when no clock edge occurs.

A synchronous, active-high reset returns the machine to state 00. The 2-bit state is brought out for observation. Bit 1 carries A and bit 0 carries B.

A parameter picks how the next-state logic is built. One variant is a direct sum-of-products form. The other is a full case table. The behaviour at the ports is the same for both.

Top module: `mealy2_fsm`

## Requirements
- R1: When `rst_i` is 1 at a rising edge, the state becomes 00 after that edge, whatever `x_i` is.
- R2: With reset low, the new A (state bit 1) after a rising edge equals (A and x) or (B and x), using the values before the edge.
- R3: With reset low, the new B (state bit 0) after a rising edge equals (not A) and x, using the values before the edge.
- R4: `y_o` equals (A or B) and not x at every moment, with no clock delay.
- R5: When x is 0, every state moves to 00 at the next edge. `y_o` is 1 while the state is 01, 10 or 11, and 0 while the state is 00.
- R6: When x is 1, the moves are 00→01, 01→11, 10→10 and 11→10, and `y_o` is 0 throughout.
- R7: If x changes between clock edges, `y_o` follows it in the same cycle while the state holds.
- R8: The state changes only at a rising clock edge. A change of x between edges leaves `state_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high, forces state 00 |
| x_i | input | 1 | Serial data input |
| y_o | output | 1 | Mealy output, (A or B) and not x |
| state_o | output | 2 | Present state; bit 1 is A, bit 0 is B |

## Verification
The bench builds the block twice, side by side. One copy uses `NEXT_STYLE` = 0, the equation form of the next-state logic. The other uses `NEXT_STYLE` = 1, the case-table form. Both copies see the same stimulus and are checked against one model computed in the bench.

With only four states and one input bit, a sweep can cover everything. It starts from reset, walks to each state and applies each input value, so every transition and every output value is checked for both variants. A pseudo-random walk, a reset applied from a non-zero state, and input changes between edges then exercise the Mealy path and the edge-only state update.

// File: rtl/mealy2_pkg.sv
package mealy2_pkg;

   localparam int STATE_W = 2;

   typedef struct packed {
      logic a;
      logic b;
   } mealy2_state_t;

   localparam mealy2_state_t ST_IDLE = '{a: 1'b0, b: 1'b0};

   localparam int STYLE_EQN   = 0;
   localparam int STYLE_TABLE = 1;

endpackage

// File: rtl/mealy2_next.sv
module mealy2_next
   import mealy2_pkg::*;
#(
   parameter int NEXT_STYLE = STYLE_EQN
) (
   input  mealy2_state_t cur_i,
   input  logic          x_i,
   output mealy2_state_t nxt_o
);

   initial begin
      if (NEXT_STYLE != STYLE_EQN && NEXT_STYLE != STYLE_TABLE)
         $error("mealy2_next: NEXT_STYLE must be 0 or 1");
   end

   generate
      if (NEXT_STYLE == STYLE_EQN) begin : g_eqn
         always_comb begin
            nxt_o.a = (cur_i.a & x_i) | (cur_i.b & x_i);
            nxt_o.b = ~cur_i.a & x_i;
         end
      end else begin : g_table
         always_comb begin
            case ({cur_i.a, cur_i.b, x_i})
               3'b001:  nxt_o = '{a: 1'b0, b: 1'b1};
               3'b011:  nxt_o = '{a: 1'b1, b: 1'b1};
               3'b101:  nxt_o = '{a: 1'b1, b: 1'b0};
               3'b111:  nxt_o = '{a: 1'b1, b: 1'b0};
               default: nxt_o = ST_IDLE;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/mealy2_out.sv
module mealy2_out
   import mealy2_pkg::*;
(
   input  mealy2_state_t cur_i,
   input  logic          x_i,
   output logic          y_o
);

   logic any_set;

   always_comb begin
      any_set = cur_i.a | cur_i.b;
      y_o     = any_set & ~x_i;
   end

endmodule

// File: rtl/mealy2_state_reg.sv
module mealy2_state_reg
   import mealy2_pkg::*;
(
   input  logic          clk_i,
   input  logic          rst_i,
   input  mealy2_state_t nxt_i,
   output mealy2_state_t cur_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) cur_o <= ST_IDLE;
      else       cur_o <= nxt_i;
   end

endmodule

// File: rtl/mealy2_fsm.sv
module mealy2_fsm
   import mealy2_pkg::*;
#(
   parameter int NEXT_STYLE = STYLE_EQN
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               x_i,
   output logic               y_o,
   output logic [STATE_W-1:0] state_o
);

   mealy2_state_t cur_s;
   mealy2_state_t nxt_s;

   mealy2_next #(.NEXT_STYLE(NEXT_STYLE)) u_next (
      .cur_i (cur_s),
      .x_i   (x_i),
      .nxt_o (nxt_s)
   );

   mealy2_state_reg u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .nxt_i (nxt_s),
      .cur_o (cur_s)
   );

   mealy2_out u_out (
      .cur_i (cur_s),
      .x_i   (x_i),
      .y_o   (y_o)
   );

   assign state_o = {cur_s.a, cur_s.b};

endmodule

// File: rtl/mealy2_fsm_chk.sv
module mealy2_fsm_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       x_i,
   input logic       y_o,
   input logic [1:0] state_o
);

   // R1
   p_reset_r1: assert property (@(posedge clk_i) rst_i |=> state_o == 2'b00);

   // R2
   p_next_a_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> state_o[1] == (($past(state_o[1]) | $past(state_o[0])) & $past(x_i)));

   // R3
   p_next_b_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> state_o[0] == (!$past(state_o[1]) && $past(x_i)));

   // R5
   p_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      !x_i |=> state_o == 2'b00);

   // R6
   p_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      x_i |-> !y_o);

   // R4
   p_flag_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!x_i && state_o != 2'b00) |-> y_o);

endmodule

bind mealy2_fsm mealy2_fsm_chk u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .x_i     (x_i),
   .y_o     (y_o),
   .state_o (state_o)
);

// File: tb/tb_mealy2_fsm.sv
`timescale 1ns/1ps
module tb_mealy2_fsm;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       x   = 1'b0;
   logic       y0, y1;
   logic [1:0] st0, st1;
   logic [1:0] exp_st;
   int         checks = 0;
   int         errors = 0;
   bit         done   = 1'b0;

   always #5 clk = ~clk;

   mealy2_fsm #(.NEXT_STYLE(0)) dut (
      .clk_i(clk), .rst_i(rst), .x_i(x), .y_o(y0), .state_o(st0));

   mealy2_fsm #(.NEXT_STYLE(1)) dut_alt (
      .clk_i(clk), .rst_i(rst), .x_i(x), .y_o(y1), .state_o(st1));

   function automatic logic [1:0] model_next(input logic [1:0] s, input logic xv);
      logic a, b;
      a = s[1];
      b = s[0];
      return {(a & xv) | (b & xv), ~a & xv};
   endfunction

   function automatic logic model_y(input logic [1:0] s, input logic xv);
      return (s[1] | s[0]) & ~xv;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_both_state(input string req);
      chk({req, " state"},     st0, exp_st);
      chk({req, " state alt"}, st1, exp_st);
   endtask

   task automatic chk_both_y(input string req, input logic e);
      chk({req, " y"},     y0, e);
      chk({req, " y alt"}, y1, e);
   endtask

   task automatic do_reset(input logic xv);
      @(negedge clk);
      rst = 1'b1;
      x   = xv;
      @(posedge clk);
      #1;
      exp_st = 2'b00;
      chk_both_state("R1 reset");
      @(negedge clk);
      rst = 1'b0;
      x   = 1'b0;
   endtask

   task automatic step(input logic xv);
      string tag;
      @(negedge clk);
      x = xv;
      #1;
      tag = xv ? "R6/R4" : "R5/R4";
      chk_both_y(tag, model_y(exp_st, xv));
      @(posedge clk);
      #1;
      exp_st = model_next(exp_st, xv);
      chk_both_state(xv ? "R2/R3/R6" : "R2/R3/R5");
   endtask

   initial begin
      logic [7:0] lfsr;
      #2;
      @(posedge clk);
      @(posedge clk);
      #1;
      exp_st = 2'b00;
      chk_both_state("R1 power-up");
      @(negedge clk);
      rst = 1'b0;

      // exhaustive sweep: every state, every input value
      for (int s = 0; s < 4; s++) begin
         for (int xv = 0; xv < 2; xv++) begin
            do_reset(1'b0);
            if (s == 1) step(1'b1);
            if (s == 3) begin step(1'b1); step(1'b1); end
            if (s == 2) begin step(1'b1); step(1'b1); step(1'b1); end
            chk_both_state("R6 reach");
            step(xv[0]);
         end
      end

      // R1: reset from state 11 with x held high
      do_reset(1'b0);
      step(1'b1);
      step(1'b1);
      do_reset(1'b1);

      // R7 and R8: x changes between edges in state 01
      step(1'b1);
      @(negedge clk);
      x = 1'b0;
      #1;
      chk_both_y("R7 x=0", 1'b1);
      #1;
      x = 1'b1;
      #1;
      chk_both_y("R7 x=1", 1'b0);
      chk_both_state("R8 mid-cycle");
      #1;
      x = 1'b0;
      #1;
      chk_both_y("R7 x back", 1'b1);
      chk_both_state("R8 mid-cycle again");
      @(posedge clk);
      #1;
      exp_st = model_next(exp_st, 1'b0);
      chk_both_state("R5 after glitch");

      // pseudo-random walk
      lfsr = 8'hA5;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(lfsr[0]);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule